// File: doc/BRIEF.md
# Out-of-Order Issue Queue Slot Bookkeeping

This block keeps the books for an out-of-order issue queue. Dispatch writes renamed instructions into it, each carrying a sequence number, a flag saying it touches memory, and a flag saying it must not run speculatively. The block tells dispatch which slot the next instruction will land in and how many slots are still free. It shows the scheduler two ready vectors, one for ordinary operations and one for memory operations, and takes back a grant vector from the scheduler. Operand wakeup and pick policy live outside the block. They arrive as a per-slot operand-ready vector and the grant vector.

Entries sit in a circular list in age order, with the oldest at the head. An ordinary operation gives up its slot as soon as it is granted. A memory operation keeps its slot until a completion names that slot. An instruction that must not run speculatively stays parked until a release carries its sequence number.

A squash carries a boundary sequence number. It reclaims every younger entry, scanning from the tail toward the head. Reclaimed entries stay in the list, marked as issued, so that they drain through commit. A commit carrying a sequence number retires from the head every entry at or below that number.

Sequence numbers must rise monotonically along the list and must not wrap while entries are live. The list depth must be a power of two.

Top module: `iq_book`

## Requirements
- R1: After reset `free_cnt` equals DEPTH and no slot is live. It drops by one for each accepted insert and rises by one for each slot released in a cycle. An accepted insert lands in the slot shown on `ins_slot`, and consecutive inserts take consecutive slots modulo DEPTH.
- R2: An insert presented while `free_cnt` is zero or all DEPTH list positions are live raises `ins_err` in that same cycle, and nothing is stored.
- R3: A granted entry without the memory flag releases its slot at the clock edge that accepts the grant, so its `held_vec` bit reads 0 afterwards.
- R4: A granted memory entry keeps its `held_vec` bit until `md_valid` names its slot. A completion naming a slot that does not hold an issued memory entry has no effect.
- R5: A memory entry whose operands are ready appears only on `mem_rdy` and never on `alu_rdy`. A non-memory entry appears only on `alu_rdy`.
- R6: An entry inserted with `ins_nonspec` is on neither ready vector until `rel_valid` arrives with a `rel_seq` equal to its sequence number. After that it becomes eligible once its operand-ready bit is set.
- R7: A squash walks the list from the youngest entry toward the oldest. It affects every entry whose sequence number is greater than `sq_seq` and stops at the first entry at or below it.
- R8: Within that range, an entry is reclaimed only if it has not issued, or if it is a memory entry still holding its slot. An entry that was already squashed is skipped. A reclaimed entry stays live, leaves both ready vectors for good, and its slot returns to `free_cnt`.
- R9: `cm_valid` with `cm_seq` = N retires from the head every contiguous live entry whose sequence number is at most N, and any slot such an entry still holds is released.
- R10: When an insert and a squash fall in the same cycle, the squash wins. An insert whose sequence number is greater than `sq_seq` is dropped without raising `ins_err`. An older insert is handled as usual.
- R11: In every cycle, `free_cnt` equals DEPTH minus the number of set bits in `held_vec`.
- R12: A grant on a slot that is not on either ready vector has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request from dispatch |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_mem | input | 1 | Inserted instruction is a memory operation |
| ins_nonspec | input | 1 | Inserted instruction must wait for a release |
| ins_slot | output | PTR_W | Slot the next accepted insert will occupy |
| ins_err | output | 1 | Insert presented with no room |
| free_cnt | output | CNT_W | Number of unallocated slots |
| opnd_rdy | input | DEPTH | Per-slot operands-ready bits from wakeup |
| grant | input | DEPTH | Per-slot issue grants from the picker |
| alu_rdy | output | DEPTH | Eligible non-memory entries |
| mem_rdy | output | DEPTH | Eligible memory entries |
| md_valid | input | 1 | Memory completion event |
| md_slot | input | PTR_W | Slot of the completing memory entry |
| rel_valid | input | 1 | Release of a parked entry |
| rel_seq | input | SEQ_W | Sequence number being released |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash boundary; younger entries are reclaimed |
| cm_valid | input | 1 | Commit request |
| cm_seq | input | SEQ_W | Commit bound; head entries at or below it retire |
| live_vec | output | DEPTH | Slots occupied in the age list |
| held_vec | output | DEPTH | Slots still allocated |

## Verification
Three pairs of events can land on the same clock edge: an insert and a squash, a grant and a squash on one entry, and a memory completion and a squash on one entry. The first pair is provoked on purpose by two directed steps. In one, the insert is younger than the boundary and must vanish without an error. In the other, the boundary lies above the incoming number and the insert must be accepted. The other two collisions come from a long randomized phase that fires squashes, grants and completions together. A behavioural queue model applies squash first, then grants, completions, releases, commit and finally the insert. It is compared against every output on every cycle, and the slot counter must always match the held slots.

// File: rtl/iq_pkg.sv
package iq_pkg;

    // Per-slot state flags kept by every queue entry
    typedef struct packed {
        logic valid;      // occupies a position in the age list
        logic alloc;      // slot counted against capacity
        logic issued;     // granted, or forced issued by a squash
        logic squashed;   // reclaimed by a squash, draining to commit
        logic mem;        // memory operation
        logic nonspec;    // inserted as must-wait
        logic can_issue;  // released (or never parked)
    } iq_flags_t;

    localparam iq_flags_t IQ_FLAGS_EMPTY = '0;

    // Builds the flag set for a freshly written entry
    function automatic iq_flags_t iq_new_flags(input logic is_mem, input logic is_nonspec);
        iq_flags_t f;
        f           = IQ_FLAGS_EMPTY;
        f.valid     = 1'b1;
        f.alloc     = 1'b1;
        f.mem       = is_mem;
        f.nonspec   = is_nonspec;
        f.can_issue = ~is_nonspec;
        return f;
    endfunction

endpackage

// File: rtl/iq_entry.sv
module iq_entry
    import iq_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEQ_W-1:0] wr_seq,
    input  logic             wr_mem,
    input  logic             wr_nonspec,
    input  logic             opnd_rdy,
    input  logic             grant,
    input  logic             reclaim,
    input  logic             retire,
    input  logic             md_hit,
    input  logic             rel_valid,
    input  logic [SEQ_W-1:0] rel_seq,
    output logic [SEQ_W-1:0] seq,
    output logic             live,
    output logic             held,
    output logic             issued,
    output logic             squashed,
    output logic             is_mem,
    output logic             alu_rdy,
    output logic             mem_rdy,
    output logic             freed
);

    iq_flags_t        st, st_nxt;
    logic [SEQ_W-1:0] seq_q;
    logic             elig, grant_ok, md_ok, rel_ok;

    assign elig     = st.valid & st.alloc & ~st.issued & st.can_issue & opnd_rdy;
    assign grant_ok = grant & elig & ~reclaim;
    assign md_ok    = md_hit & st.valid & st.alloc & st.mem & st.issued & ~st.squashed;
    assign rel_ok   = rel_valid & st.valid & st.nonspec & ~st.can_issue & (seq_q == rel_seq);

    always_comb begin
        st_nxt = st;
        if (wr_en) begin
            st_nxt = iq_new_flags(wr_mem, wr_nonspec);
        end else begin
            if (reclaim) begin
                st_nxt.squashed = 1'b1;
                st_nxt.issued   = 1'b1;
                st_nxt.alloc    = 1'b0;
            end
            if (grant_ok) begin
                st_nxt.issued = 1'b1;
                if (!st.mem) st_nxt.alloc = 1'b0;
            end
            if (md_ok)  st_nxt.alloc     = 1'b0;
            if (rel_ok) st_nxt.can_issue = 1'b1;
            if (retire) begin
                st_nxt.valid = 1'b0;
                st_nxt.alloc = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= IQ_FLAGS_EMPTY;
            seq_q <= '0;
        end else begin
            st <= st_nxt;
            if (wr_en) seq_q <= wr_seq;
        end
    end

    assign seq      = seq_q;
    assign live     = st.valid;
    assign held     = st.alloc;
    assign issued   = st.issued;
    assign squashed = st.squashed;
    assign is_mem   = st.mem;
    assign alu_rdy  = elig & ~st.mem;
    assign mem_rdy  = elig & st.mem;
    assign freed    = st.alloc & ~st_nxt.alloc;

    // R3: a granted non-memory entry no longer holds its slot
    a_r3_alu_slot_freed: assert property (@(posedge clk) disable iff (rst)
        (grant_ok && !st.mem) |=> !st.alloc);

    // R4: a granted memory entry keeps its slot unless squashed or retired
    a_r4_mem_slot_kept: assert property (@(posedge clk) disable iff (rst)
        (grant_ok && st.mem && !reclaim && !retire) |=> st.alloc);

    // R6: a parked entry is never offered to the scheduler
    a_r6_parked_silent: assert property (@(posedge clk) disable iff (rst)
        (st.valid && !st.can_issue) |-> !(alu_rdy || mem_rdy));

    // R8: a reclaimed entry stays live, drains, and gives up its slot
    a_r8_reclaim_drains: assert property (@(posedge clk) disable iff (rst)
        (reclaim && !retire) |=> (st.valid && st.squashed && st.issued && !st.alloc));

endmodule

// File: rtl/iq_scan.sv
module iq_scan #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [PTR_W-1:0] head,
    input  logic [CNT_W-1:0] list_cnt,
    input  logic [SEQ_W-1:0] seqs [DEPTH],
    input  logic [DEPTH-1:0] issued,
    input  logic [DEPTH-1:0] squashed,
    input  logic [DEPTH-1:0] is_mem,
    input  logic [DEPTH-1:0] held,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic             cm_valid,
    input  logic [SEQ_W-1:0] cm_seq,
    output logic [DEPTH-1:0] reclaim,
    output logic [DEPTH-1:0] retire,
    output logic [CNT_W-1:0] retire_n
);

    logic [PTR_W-1:0] s_sq, s_cm;
    logic             sq_going, cm_going;

    // Squash: youngest to oldest, stop at the first entry at or below the boundary
    always_comb begin
        reclaim  = '0;
        sq_going = sq_valid;
        s_sq     = '0;
        for (int p = DEPTH - 1; p >= 0; p--) begin
            s_sq = head + PTR_W'(p);
            if (sq_going && (CNT_W'(p) < list_cnt)) begin
                if (seqs[s_sq] > sq_seq) begin
                    if (!squashed[s_sq] && (!issued[s_sq] || (is_mem[s_sq] && held[s_sq])))
                        reclaim[s_sq] = 1'b1;
                end else begin
                    sq_going = 1'b0;
                end
            end
        end
    end

    // Commit: oldest forward, contiguous entries at or below the bound
    always_comb begin
        retire   = '0;
        retire_n = '0;
        cm_going = cm_valid;
        s_cm     = '0;
        for (int p = 0; p < DEPTH; p++) begin
            s_cm = head + PTR_W'(p);
            if (cm_going && (CNT_W'(p) < list_cnt) && (seqs[s_cm] <= cm_seq)) begin
                retire[s_cm] = 1'b1;
                retire_n     = retire_n + 1'b1;
            end else begin
                cm_going = 1'b0;
            end
        end
    end

endmodule

// File: rtl/iq_credit.sv
module iq_credit #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [DEPTH-1:0] freed,
    output logic [CNT_W-1:0] free_cnt
);

    logic [CNT_W-1:0] free_q;
    logic [CNT_W-1:0] back_n;

    assign back_n = CNT_W'($countones(freed));

    always_ff @(posedge clk) begin
        if (rst) free_q <= CNT_W'(DEPTH);
        else     free_q <= free_q + back_n - CNT_W'(take);
    end

    assign free_cnt = free_q;

    // R1: the count moves only on an accepted insert or a released slot
    a_r1_free_hold: assert property (@(posedge clk) disable iff (rst)
        (!take && (freed == '0)) |=> $stable(free_q));

    // R1: the count never exceeds capacity
    a_r1_free_bound: assert property (@(posedge clk) disable iff (rst)
        free_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/iq_book.sv
module iq_book #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_valid,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic             ins_mem,
    input  logic             ins_nonspec,
    output logic [PTR_W-1:0] ins_slot,
    output logic             ins_err,
    output logic [CNT_W-1:0] free_cnt,
    input  logic [DEPTH-1:0] opnd_rdy,
    input  logic [DEPTH-1:0] grant,
    output logic [DEPTH-1:0] alu_rdy,
    output logic [DEPTH-1:0] mem_rdy,
    input  logic             md_valid,
    input  logic [PTR_W-1:0] md_slot,
    input  logic             rel_valid,
    input  logic [SEQ_W-1:0] rel_seq,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic             cm_valid,
    input  logic [SEQ_W-1:0] cm_seq,
    output logic [DEPTH-1:0] live_vec,
    output logic [DEPTH-1:0] held_vec
);

    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] list_cnt_q;
    logic [SEQ_W-1:0] seqs [DEPTH];
    logic [DEPTH-1:0] issued_v, squashed_v, mem_v, freed_v;
    logic [DEPTH-1:0] reclaim_v, retire_v;
    logic [CNT_W-1:0] retire_n;
    logic             drop, room, accept;

    // Squash wins over a younger insert in the same cycle
    assign drop    = sq_valid && (ins_seq > sq_seq);
    assign room    = (free_cnt != '0) && (list_cnt_q != CNT_W'(DEPTH));
    assign accept  = ins_valid && !drop && room;
    assign ins_err = ins_valid && !drop && !room;
    assign ins_slot = tail_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            iq_entry #(.SEQ_W(SEQ_W)) u_ent (
                .clk        (clk),
                .rst        (rst),
                .wr_en      (accept && (tail_q == PTR_W'(i))),
                .wr_seq     (ins_seq),
                .wr_mem     (ins_mem),
                .wr_nonspec (ins_nonspec),
                .opnd_rdy   (opnd_rdy[i]),
                .grant      (grant[i]),
                .reclaim    (reclaim_v[i]),
                .retire     (retire_v[i]),
                .md_hit     (md_valid && (md_slot == PTR_W'(i))),
                .rel_valid  (rel_valid),
                .rel_seq    (rel_seq),
                .seq        (seqs[i]),
                .live       (live_vec[i]),
                .held       (held_vec[i]),
                .issued     (issued_v[i]),
                .squashed   (squashed_v[i]),
                .is_mem     (mem_v[i]),
                .alu_rdy    (alu_rdy[i]),
                .mem_rdy    (mem_rdy[i]),
                .freed      (freed_v[i])
            );
        end
    endgenerate

    iq_scan #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_scan (
        .head     (head_q),
        .list_cnt (list_cnt_q),
        .seqs     (seqs),
        .issued   (issued_v),
        .squashed (squashed_v),
        .is_mem   (mem_v),
        .held     (held_vec),
        .sq_valid (sq_valid),
        .sq_seq   (sq_seq),
        .cm_valid (cm_valid),
        .cm_seq   (cm_seq),
        .reclaim  (reclaim_v),
        .retire   (retire_v),
        .retire_n (retire_n)
    );

    iq_credit #(.DEPTH(DEPTH)) u_credit (
        .clk      (clk),
        .rst      (rst),
        .take     (accept),
        .freed    (freed_v),
        .free_cnt (free_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q     <= '0;
            tail_q     <= '0;
            list_cnt_q <= '0;
        end else begin
            head_q     <= head_q + PTR_W'(retire_n);
            tail_q     <= tail_q + PTR_W'(accept);
            list_cnt_q <= list_cnt_q - retire_n + CNT_W'(accept);
        end
    end

    // R11: slot counter agrees with the slots the entries hold
    a_r11_free_matches_held: assert property (@(posedge clk) disable iff (rst)
        free_cnt == (CNT_W'(DEPTH) - CNT_W'($countones(held_vec))));

    // R2: a refused insert never grows the list
    a_r2_refused_not_stored: assert property (@(posedge clk) disable iff (rst)
        ins_err |=> (list_cnt_q <= $past(list_cnt_q)));

    // R10: an insert dropped by a squash is not reported as an error
    a_r10_drop_quiet: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && sq_valid && (ins_seq > sq_seq)) |-> !ins_err);

    // R9: the live count tracks the live bits
    a_r9_list_count: assert property (@(posedge clk) disable iff (rst)
        list_cnt_q == CNT_W'($countones(live_vec)));

endmodule

// File: tb/tb_iq_book.sv
`timescale 1ns/1ps
module tb_iq_book;

    localparam int DEPTH = 8;
    localparam int SEQ_W = 16;
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic             ins_valid, ins_mem, ins_nonspec;
    logic [SEQ_W-1:0] ins_seq;
    logic [PTR_W-1:0] ins_slot;
    logic             ins_err;
    logic [CNT_W-1:0] free_cnt;
    logic [DEPTH-1:0] opnd_rdy, grant, alu_rdy, mem_rdy, live_vec, held_vec;
    logic             md_valid, rel_valid, sq_valid, cm_valid;
    logic [PTR_W-1:0] md_slot;
    logic [SEQ_W-1:0] rel_seq, sq_seq, cm_seq;

    always #4 clk = ~clk;

    iq_book #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) dut (.*);

    typedef struct {
        int seq; int slot;
        bit mem; bit ns; bit can; bit iss; bit sq; bit held;
    } ment_t;

    ment_t q[$];
    int    m_free, m_tail;
    int    checks = 0, errors = 0;
    int    next_seq = 10;

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clr();
        ins_valid = 0; ins_mem = 0; ins_nonspec = 0; ins_seq = '0;
        grant = '0; md_valid = 0; md_slot = '0; rel_valid = 0; rel_seq = '0;
        sq_valid = 0; sq_seq = '0; cm_valid = 0; cm_seq = '0;
    endtask

    function automatic bit m_drop();
        return sq_valid && (int'(ins_seq) > int'(sq_seq));
    endfunction

    task automatic compare_all();
        logic [DEPTH-1:0] e_alu, e_mem, e_live, e_held;
        bit room;
        e_alu = '0; e_mem = '0; e_live = '0; e_held = '0;
        foreach (q[i]) begin
            e_live[q[i].slot] = 1'b1;
            e_held[q[i].slot] = q[i].held;
            if (q[i].held && !q[i].iss && q[i].can && opnd_rdy[q[i].slot]) begin
                if (q[i].mem) e_mem[q[i].slot] = 1'b1;
                else          e_alu[q[i].slot] = 1'b1;
            end
        end
        room = (m_free != 0) && (q.size() < DEPTH);
        chk("R1 free_cnt", free_cnt, m_free);
        chk("R1 ins_slot", ins_slot, m_tail);
        chk("R2 ins_err", ins_err, ins_valid && !m_drop() && !room);
        chk("R6 alu_rdy", alu_rdy, e_alu);
        chk("R5 mem_rdy", mem_rdy, e_mem);
        chk("R9 live_vec", live_vec, e_live);
        chk("R3 held_vec", held_vec, e_held);
        chk("R11 free_vs_held", free_cnt, DEPTH - $countones(held_vec));
    endtask

    task automatic model_step();
        bit pre_elig[$], pre_iss[$], pre_sq[$], pre_held[$], recl[$];
        int f0, n0;
        bit do_ins;
        ment_t ne;
        f0 = m_free; n0 = q.size();
        foreach (q[i]) begin
            pre_elig.push_back(q[i].held && !q[i].iss && q[i].can && opnd_rdy[q[i].slot]);
            pre_iss.push_back(q[i].iss); pre_sq.push_back(q[i].sq);
            pre_held.push_back(q[i].held); recl.push_back(1'b0);
        end
        do_ins = ins_valid && !m_drop() && f0 != 0 && n0 < DEPTH;
        if (sq_valid) begin
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].seq <= int'(sq_seq)) break;
                if (q[i].sq) continue;
                if (!q[i].iss || (q[i].mem && q[i].held)) begin
                    recl[i] = 1'b1; q[i].sq = 1; q[i].iss = 1;
                    if (q[i].held) begin q[i].held = 0; m_free++; end
                end
            end
        end
        foreach (q[i]) begin
            if (grant[q[i].slot] && pre_elig[i] && !recl[i]) begin
                q[i].iss = 1;
                if (!q[i].mem) begin q[i].held = 0; m_free++; end
            end
            if (md_valid && md_slot == PTR_W'(q[i].slot) && pre_held[i] && q[i].mem
                && pre_iss[i] && !pre_sq[i] && q[i].held) begin
                q[i].held = 0; m_free++;
            end
            if (rel_valid && q[i].ns && !q[i].can && q[i].seq == int'(rel_seq))
                q[i].can = 1;
        end
        if (cm_valid) begin
            while (q.size() > 0 && q[0].seq <= int'(cm_seq)) begin
                if (q[0].held) m_free++;
                void'(q.pop_front());
            end
        end
        if (do_ins) begin
            ne = '{seq: int'(ins_seq), slot: m_tail, mem: ins_mem, ns: ins_nonspec,
                   can: !ins_nonspec, iss: 0, sq: 0, held: 1};
            q.push_back(ne);
            m_free--;
            m_tail = (m_tail + 1) % DEPTH;
        end
    endtask

    task automatic cycle();
        #1;
        compare_all();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic put(bit mem, bit ns);
        clr();
        ins_valid = 1; ins_seq = SEQ_W'(next_seq); ins_mem = mem; ins_nonspec = ns;
        next_seq++;
        cycle();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clr();
        opnd_rdy = '1;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        q.delete(); m_free = DEPTH; m_tail = 0;
        chk("R1 reset free", free_cnt, DEPTH);
        chk("R1 reset live", live_vec, 0);

        // seq 10 alu s0, 11 mem s1, 12 parked alu s2, 13 alu s3
        put(0, 0); put(1, 0); put(0, 1); put(0, 0);
        chk("R5 mem only on mem_rdy", {alu_rdy, mem_rdy}, {8'b0000_1001, 8'b0000_0010});
        chk("R6 parked not offered", alu_rdy[2], 0);
        clr(); grant = 8'b0000_0100; cycle();
        chk("R12 grant ignored", {held_vec, 4'(free_cnt)}, {8'b0000_1111, 4'd4});
        clr(); grant = 8'b0000_0011; cycle();
        chk("R3 alu freed R4 mem held", held_vec, 8'b0000_1110);
        clr(); md_valid = 1; md_slot = 3; cycle();
        chk("R4 stray completion ignored", held_vec, 8'b0000_1110);
        clr(); md_valid = 1; md_slot = 1; cycle();
        chk("R4 completion frees", {held_vec, 4'(free_cnt)}, {8'b0000_1100, 4'd6});
        clr(); rel_valid = 1; rel_seq = 12; cycle();
        chk("R6 released", alu_rdy, 8'b0000_1100);
        // squash above 11 with a younger insert in the same cycle
        clr(); sq_valid = 1; sq_seq = 11; ins_valid = 1; ins_seq = 14; next_seq = 15;
        #1 chk("R10 drop quiet", ins_err, 0);
        cycle();
        chk("R7 R8 squash", {live_vec, held_vec, 4'(free_cnt)}, {8'b0000_1111, 8'h00, 4'd8});
        chk("R10 dropped", ins_slot, 4);
        clr(); sq_valid = 1; sq_seq = 11; cycle();
        chk("R8 already squashed skipped", {alu_rdy, 4'(free_cnt)}, {8'h00, 4'd8});
        clr(); sq_valid = 1; sq_seq = 40; ins_valid = 1; ins_seq = 15; next_seq = 16; cycle();
        chk("R10 older insert kept", live_vec, 8'b0001_1111);
        clr(); cm_valid = 1; cm_seq = 12; cycle();
        chk("R9 commit retires head", live_vec, 8'b0001_1000);
        for (int k = 0; k < 6; k++) put(1, 0);
        clr(); ins_valid = 1; ins_seq = SEQ_W'(next_seq); next_seq++;
        #1 chk("R2 full insert refused", ins_err, 1);
        cycle();
        chk("R2 nothing stored", live_vec, 8'hFF);
        clr(); cm_valid = 1; cm_seq = 16'hFFFF; cycle();
        chk("R9 commit all", {live_vec, 4'(free_cnt)}, {8'h00, 4'd8});

        // randomized phase
        for (int c = 0; c < 4000; c++) begin
            clr();
            opnd_rdy = DEPTH'($urandom);
            grant    = DEPTH'($urandom);
            if ($urandom % 3 != 0) begin
                ins_valid = 1; ins_seq = SEQ_W'(next_seq); next_seq++;
                ins_mem = ($urandom % 3 == 0); ins_nonspec = ($urandom % 5 == 0);
            end
            if ($urandom % 4 == 0) begin md_valid = 1; md_slot = PTR_W'($urandom); end
            if (q.size() > 0 && $urandom % 4 == 0) begin
                rel_valid = 1; rel_seq = SEQ_W'(q[$urandom % q.size()].seq);
            end
            if ($urandom % 9 == 0) begin
                sq_valid = 1; sq_seq = SEQ_W'(next_seq - 2 - int'($urandom % 5));
            end
            if (q.size() > 0 && $urandom % 4 == 0) begin
                cm_valid = 1; cm_seq = SEQ_W'(q[0].seq + int'($urandom % 4));
            end
            cycle();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule